// File: doc/BRIEF.md
# Packet Receive FIFO with End-of-Packet Tagging

This block is a byte FIFO placed between a serial frame receiver and a host. Each stored entry holds a data byte and a 2-bit end code. The code marks whether the byte ends a frame and, if so, how the frame ended: a normal byte, a good end, an abort, or a bad CRC or invalid frame. The host pops bytes one at a time. A registered look-ahead output tells the host whether the byte now at the head of the queue closes a packet, so the host can find packet boundaries without reading ahead.

The block watches its own fill level. It emits a one-cycle pulse when the level crosses a programmable threshold. When the receiver writes into a completely full queue, the byte is dropped and an overflow pulse fires. Further receiver writes are then refused until the receiver reports a flag. If the host has not made room by then, the next write overflows again.

The read port has one cycle of latency: the byte and code popped by a read request appear on the outputs after the next rising edge. Reset is synchronous and active high.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, level is 0, wr_locked is 0, and eop_rd, eop_wr_pulse, full_pulse, ovfl_pulse, rd_data and rd_code are all 0.
- R2: Bytes and their end codes leave the FIFO in the order they were accepted. A read request while level is nonzero presents the head byte on rd_data and its code on rd_code after the next rising edge, and lowers level by one.
- R3: End codes are 2'b00 normal byte, 2'b01 good end, 2'b10 abort, and 2'b11 bad CRC or invalid frame. Each accepted write with a nonzero code makes eop_wr_pulse high for exactly the one cycle after that edge.
- R4: eop_rd is high after an edge exactly when level is nonzero and the entry at the read head has a nonzero code. This also covers a byte written into an empty FIFO in that same edge.
- R5: A read request while level is 0 returns rd_data 0 and rd_code 0 and pulses eop_rd for one cycle. It leaves level and the read position unchanged.
- R6: full_pulse is high for one cycle after an edge at which level goes from at most full_thresh to above full_thresh.
- R7: A write request while unlocked and level is DEPTH (128) raises ovfl_pulse for one cycle and sets wr_locked. The byte is discarded and the stored bytes are not altered.
- R8: While wr_locked is 1, write requests neither store data nor raise ovfl_pulse. Reads continue normally.
- R9: flag_seen clears wr_locked at the next edge. A write made after that while level is still DEPTH overflows again.
- R10: A read and a write in the same cycle with level between 1 and DEPTH-1 both take effect and leave level unchanged. The overflow decision uses the level before the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver write request |
| wr_data | input | DATA_W | Byte to store |
| wr_code | input | 2 | End code stored with the byte |
| flag_seen | input | 1 | Receiver saw a flag; releases the write lock |
| full_thresh | input | LVL_W | Full threshold for full_pulse |
| rd_en | input | 1 | Host read request |
| rd_data | output | DATA_W | Byte popped by the previous read |
| rd_code | output | 2 | End code of the popped byte |
| eop_rd | output | 1 | Head byte ends a packet, or empty read happened |
| eop_wr_pulse | output | 1 | An end-tagged byte was stored |
| full_pulse | output | 1 | Level rose above full_thresh |
| ovfl_pulse | output | 1 | Write attempted into a full FIFO |
| wr_locked | output | 1 | Writes refused until next flag |
| level | output | LVL_W | Number of stored bytes |

## Verification
The hardest state to reach is the locked state on a completely full queue, followed by its two exits. To reach it, the stimulus fills all 128 entries with a known ramp. It then overflows the queue, writes while locked, and releases the lock with a flag while the queue is still full, which forces a second overflow. Next it drains one byte, is refused again, releases again, and stores one abort-tagged byte. Reading the whole ramp back afterwards shows that no discarded byte got in and no stored byte was changed. The look-ahead is checked on the ramp's final, good-end byte.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_GOOD  = 2'b01,
    END_ABORT = 2'b10,
    END_BAD   = 2'b11
  } end_code_e;

  function automatic logic is_end(input logic [1:0] code);
    return end_code_e'(code) != END_NONE;
  endfunction

endpackage

// File: rtl/prf_store.sv
module prf_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        wcode,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  input  logic              rzero,
  input  logic [AW-1:0]     la_addr,
  output logic              la_end,
  output logic [DATA_W-1:0] q_data,
  output logic [1:0]        q_code
);
  import pkt_rx_fifo_pkg::*;

  localparam int EW = DATA_W + 2;

  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    q;
  logic [DEPTH-1:0] endv;

  // array without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wcode, wdata};
  end

  // registered read port, zeroed by an empty read
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (re)    q <= mem[raddr];
    else if (rzero) q <= '0;
  end

  // one end bit per entry, kept in flops for the look-ahead
  always_ff @(posedge clk) begin
    if (rst)     endv <= '0;
    else if (we) endv[waddr] <= is_end(wcode);
  end

  always_comb begin
    if (we && waddr == la_addr) la_end = is_end(wcode);
    else                        la_end = endv[la_addr];
  end

  assign q_data = q[DATA_W-1:0];
  assign q_code = q[EW-1:DATA_W];

  // R5: an empty read returns a zero entry
  a_r5_zero_on_empty: assert property (@(posedge clk) disable iff (rst)
    (rzero && !re) |=> (q_data == '0 && q_code == 2'b00));

endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          flag_seen,
  output logic          we,
  output logic [AW-1:0] wr_ptr,
  output logic          re,
  output logic          rd_empty,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] rd_ptr_n,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_n,
  output logic          locked,
  output logic          ovfl_pulse
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic empty, full, wtry, ovf;

  assign empty    = (cnt == '0);
  assign full     = (cnt == FULL);
  assign re       = rd_en && !empty;
  assign rd_empty = rd_en && empty;
  assign wtry     = wr_en && !locked;
  assign we       = wtry && !full;
  assign ovf      = wtry && full;

  always_comb begin
    cnt_n = cnt;
    if (we) cnt_n = cnt_n + CW'(1);
    if (re) cnt_n = cnt_n - CW'(1);
  end

  always_comb begin
    rd_ptr_n = rd_ptr;
    if (re) rd_ptr_n = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt        <= '0;
      locked     <= 1'b0;
      ovfl_pulse <= 1'b0;
    end else begin
      if (we) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      rd_ptr     <= rd_ptr_n;
      cnt        <= cnt_n;
      ovfl_pulse <= ovf;
      if (ovf)            locked <= 1'b1;
      else if (flag_seen) locked <= 1'b0;
    end
  end

  // R2: level never leaves its legal range
  a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  // R7: an overflow always leaves the lock set
  a_r7_ovfl_locks: assert property (@(posedge clk) disable iff (rst)
    ovfl_pulse |-> locked);

  // R8: while locked the level can only fall or hold
  a_r8_locked_no_growth: assert property (@(posedge clk) disable iff (rst)
    locked |=> cnt <= $past(cnt));

  // R8: no second overflow while the lock is held
  a_r8_no_repeat_ovfl: assert property (@(posedge clk) disable iff (rst)
    (locked && !flag_seen) |=> !ovfl_pulse);

  // R5: an empty read does not move the read position
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    rd_empty |=> $stable(rd_ptr));

endmodule

// File: rtl/prf_events.sv
module prf_events #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    wcode,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_n,
  input  logic [CW-1:0] thresh,
  input  logic          rd_empty,
  input  logic          la_end,
  output logic          eop_wr_pulse,
  output logic          full_pulse,
  output logic          eop_rd
);
  import pkt_rx_fifo_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      eop_wr_pulse <= 1'b0;
      full_pulse   <= 1'b0;
      eop_rd       <= 1'b0;
    end else begin
      eop_wr_pulse <= we && is_end(wcode);
      full_pulse   <= (cnt <= thresh) && (cnt_n > thresh);
      eop_rd       <= rd_empty || ((cnt_n != '0) && la_end);
    end
  end

  // R6: the full pulse only fires above the threshold it was compared to
  a_r6_full_above: assert property (@(posedge clk) disable iff (rst)
    full_pulse |-> cnt > $past(thresh));

  // R3: an end pulse follows only a stored, end-tagged byte
  a_r3_eop_wr_src: assert property (@(posedge clk) disable iff (rst)
    eop_wr_pulse |-> ($past(we) && $past(wcode) != 2'b00));

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter  int DEPTH  = 128,
  parameter  int DATA_W = 8,
  localparam int LVL_W  = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_code,
  input  logic              flag_seen,
  input  logic [LVL_W-1:0]  full_thresh,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_code,
  output logic              eop_rd,
  output logic              eop_wr_pulse,
  output logic              full_pulse,
  output logic              ovfl_pulse,
  output logic              wr_locked,
  output logic [LVL_W-1:0]  level
);

  localparam int AW = $clog2(DEPTH);

  logic             we, re, rd_empty, la_end;
  logic [AW-1:0]    wr_ptr, rd_ptr, rd_ptr_n;
  logic [LVL_W-1:0] cnt, cnt_n;

  prf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(LVL_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .flag_seen(flag_seen), .we(we), .wr_ptr(wr_ptr), .re(re),
    .rd_empty(rd_empty), .rd_ptr(rd_ptr), .rd_ptr_n(rd_ptr_n),
    .cnt(cnt), .cnt_n(cnt_n), .locked(wr_locked), .ovfl_pulse(ovfl_pulse)
  );

  prf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) store_i (
    .clk(clk), .rst(rst), .we(we), .waddr(wr_ptr), .wdata(wr_data),
    .wcode(wr_code), .re(re), .raddr(rd_ptr), .rzero(rd_empty),
    .la_addr(rd_ptr_n), .la_end(la_end), .q_data(rd_data), .q_code(rd_code)
  );

  prf_events #(.CW(LVL_W)) events_i (
    .clk(clk), .rst(rst), .we(we), .wcode(wr_code), .cnt(cnt),
    .cnt_n(cnt_n), .thresh(full_thresh), .rd_empty(rd_empty),
    .la_end(la_end), .eop_wr_pulse(eop_wr_pulse),
    .full_pulse(full_pulse), .eop_rd(eop_rd)
  );

  assign level = cnt;

  // R5: an empty read is flagged on the look-ahead output
  a_r5_empty_read_flag: assert property (@(posedge clk) disable iff (rst)
    (rd_en && level == '0) |=> (eop_rd && level == $past(level) + (($past(wr_en) && !$past(wr_locked)) ? 1 : 0)));

  // R4: with nothing stored and no empty read, no end is reported
  a_r4_empty_no_eop: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && !$past(rd_en)) |-> !eop_rd);

endmodule

// File: tb/pkt_rx_fifo_tb_top.sv
module pkt_rx_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, flag_seen = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_code = '0;
  logic [7:0] full_thresh = 8'd200;
  logic [7:0] rd_data;
  logic [1:0] rd_code;
  logic       eop_rd, eop_wr_pulse, full_pulse, ovfl_pulse, wr_locked;
  logic [7:0] level;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pkt_rx_fifo dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_code(wr_code), .flag_seen(flag_seen), .full_thresh(full_thresh),
    .rd_en(rd_en), .rd_data(rd_data), .rd_code(rd_code), .eop_rd(eop_rd),
    .eop_wr_pulse(eop_wr_pulse), .full_pulse(full_pulse),
    .ovfl_pulse(ovfl_pulse), .wr_locked(wr_locked), .level(level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs are sampled 1 ns after the edge
  task automatic step(input logic w, input logic r, input logic f,
                      input logic [7:0] d, input logic [1:0] c);
    @(negedge clk);
    wr_en = w; rd_en = r; flag_seen = f; wr_data = d; wr_code = c;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; flag_seen = 1'b0;
  endtask

  // op[1]=read op[0]=write, code, data, exp code, exp data, exp eop_rd, exp level
  localparam int NV = 13;
  localparam logic [30:0] VEC [NV] = '{
    {2'd1, 2'd0, 8'h11, 2'd0, 8'h00, 1'b0, 8'd1},
    {2'd1, 2'd1, 8'h22, 2'd0, 8'h00, 1'b0, 8'd2},
    {2'd1, 2'd2, 8'h33, 2'd0, 8'h00, 1'b0, 8'd3},
    {2'd2, 2'd0, 8'h00, 2'd0, 8'h11, 1'b1, 8'd2},
    {2'd2, 2'd0, 8'h00, 2'd1, 8'h22, 1'b1, 8'd1},
    {2'd3, 2'd0, 8'h44, 2'd2, 8'h33, 1'b0, 8'd1},
    {2'd1, 2'd3, 8'h55, 2'd0, 8'h00, 1'b0, 8'd2},
    {2'd2, 2'd0, 8'h00, 2'd0, 8'h44, 1'b1, 8'd1},
    {2'd2, 2'd0, 8'h00, 2'd3, 8'h55, 1'b0, 8'd0},
    {2'd1, 2'd1, 8'h66, 2'd0, 8'h00, 1'b1, 8'd1},
    {2'd2, 2'd0, 8'h00, 2'd1, 8'h66, 1'b0, 8'd0},
    {2'd3, 2'd2, 8'h77, 2'd0, 8'h00, 1'b1, 8'd1},
    {2'd2, 2'd0, 8'h00, 2'd2, 8'h77, 1'b0, 8'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 locked", wr_locked, 0);
    chk("R1 pulses", {eop_rd, eop_wr_pulse, full_pulse, ovfl_pulse}, 0);
    chk("R1 read port", {rd_code, rd_data}, 0);

    // table walk: R2 order, R3 codes, R4 look-ahead, R10 read+write
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      step(v[29], v[30], 1'b0, v[26:19], v[28:27]);
      chk("R2 level", level, v[7:0]);
      chk("R4 eop_rd", eop_rd, v[8]);
      chk("R3 eop_wr_pulse", eop_wr_pulse, v[29] && (v[28:27] != 2'b00));
      if (v[30]) chk("R2 read entry", {rd_code, rd_data}, {v[18:17], v[16:9]});
    end

    // R5 empty read on a drained FIFO after real data was read
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
    chk("R5 zero data", {rd_code, rd_data}, 0);
    chk("R5 eop pulse", eop_rd, 1);
    chk("R5 level", level, 0);
    step(1'b0, 1'b0, 1'b0, 8'h00, 2'd0);
    chk("R5 pulse ends", eop_rd, 0);

    // R6 threshold crossing at 3
    full_thresh = 8'd3;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(i), 2'd0);
      chk("R6 full_pulse", full_pulse, i == 3);
    end
    step(1'b0, 1'b0, 1'b0, 8'h00, 2'd0);
    chk("R6 single cycle", full_pulse, 0);
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
    chk("R6 falling", full_pulse, 0);
    step(1'b1, 1'b0, 1'b0, 8'h09, 2'd0);
    chk("R6 recross", full_pulse, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
    chk("R6 drained", level, 0);

    // R7 R8 R9 fill to DEPTH with a ramp, last byte good end
    full_thresh = 8'd127;
    for (int i = 0; i < 128; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(i), (i == 127) ? 2'd1 : 2'd0);
      if (i == 127) begin
        chk("R6 full at 128", full_pulse, 1);
        chk("R3 last tagged", eop_wr_pulse, 1);
      end
    end
    chk("R7 level full", level, 128);
    step(1'b1, 1'b0, 1'b0, 8'hEE, 2'd3);
    chk("R7 ovfl pulse", ovfl_pulse, 1);
    chk("R7 locked", wr_locked, 1);
    chk("R7 discarded", {eop_wr_pulse, level}, {1'b0, 8'd128});
    step(1'b1, 1'b0, 1'b0, 8'hDD, 2'd0);
    chk("R8 no second ovfl", ovfl_pulse, 0);
    chk("R8 still locked", wr_locked, 1);
    step(1'b0, 1'b0, 1'b1, 8'h00, 2'd0);
    chk("R9 unlock", wr_locked, 0);
    step(1'b1, 1'b0, 1'b0, 8'hCC, 2'd0);
    chk("R9 re-overflow", {ovfl_pulse, wr_locked}, 2'b11);
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
    chk("R8 read while locked", {rd_code, rd_data, level}, {2'd0, 8'h00, 8'd127});
    step(1'b1, 1'b0, 1'b0, 8'h99, 2'd0);
    chk("R8 write ignored", level, 127);
    step(1'b0, 1'b0, 1'b1, 8'h00, 2'd0);
    step(1'b1, 1'b0, 1'b0, 8'hAB, 2'd2);
    chk("R9 write after flag", {eop_wr_pulse, full_pulse, level}, {2'b11, 8'd128});
    for (int j = 1; j < 128; j++) begin
      step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
      chk("R7 stored ramp", {rd_code, rd_data}, {(j == 127) ? 2'd1 : 2'd0, 8'(j)});
      chk("R4 look-ahead", eop_rd, j >= 126);
    end
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0);
    chk("R9 abort byte", {rd_code, rd_data, level}, {2'd2, 8'hAB, 8'd0});
    chk("R4 drained", eop_rd, 0);

    // R1 reset while locked and nonempty
    for (int i = 0; i < 129; i++) step(1'b1, 1'b0, 1'b0, 8'h5A, 2'd1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 reset clears", {wr_locked, eop_rd, ovfl_pulse, level}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule